// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 binary floating-point operands and reports the outcome as a four-bit processor condition-flag word (negative, zero, carry, overflow) together with an invalid-operation exception bit. A format input picks 32-bit or 64-bit operands. A mode input picks a quiet compare, which treats only signalling NaNs as invalid, or a signalling compare, which treats every NaN as invalid. Subnormal operands are compared exactly. No rounding takes place, because no arithmetic result is produced.

A request is taken on a rising clock edge while `req_i` is high. The result is registered and appears on the next cycle with `vld_o` high. A small control machine tracks whether the registered result is fresh. It has two states. `ST_IDLE` means no result was produced in the last cycle. `ST_DONE` means a result was produced in the last cycle. The transitions are: IDLE to DONE on a request (capture), DONE to DONE on a back-to-back request (recapture), DONE to IDLE when no request arrives (retire), and IDLE to IDLE while no request arrives (wait). When no request is taken, the registered flags and exception bit keep their values.

Top module: `fcmp_nzcv_top`

## Requirements
- R1: When neither operand is NaN and the operands are numerically equal, the flag word is 4'b0110 (bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V).
- R2: When a is less than b (neither operand NaN), the flag word is 4'b1000.
- R3: When a is greater than b (neither operand NaN), the flag word is 4'b0010.
- R4: When either operand is NaN (exponent all ones, fraction nonzero), the flag word is 4'b0011.
- R5: With `sig_mode_i` = 0 (quiet), `inv_o` is 1 only when at least one operand is a signalling NaN, meaning the fraction's top bit is 0. A quiet NaN (fraction top bit 1) gives `inv_o` = 0.
- R6: With `sig_mode_i` = 1 (signalling), `inv_o` is 1 whenever either operand is any NaN, and 0 otherwise.
- R7: With `fmt_dbl_i` = 1 the full 64-bit operands are compared as double precision. With `fmt_dbl_i` = 0 only bits [31:0] are compared as single precision, and bits [63:32] have no effect.
- R8: Positive zero and negative zero compare equal.
- R9: Infinities order by sign like finite values: negative infinity is below everything else, positive infinity is above everything else, and two infinities of the same sign compare equal.
- R10: Subnormal operands are compared exactly, with no flush to zero, so adjacent subnormals order correctly.
- R11: A request taken at one clock edge gives `vld_o` = 1 with the result in the following cycle. A cycle with no request gives `vld_o` = 0 in the following cycle, while `flags_o` and `inv_o` hold their previous values.
- R12: While reset is asserted and just after it is released, `vld_o`, `flags_o` and `inv_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Compare request, sampled on the rising edge |
| fmt_dbl_i | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands in bits [31:0] |
| sig_mode_i | input | 1 | 1 = signalling compare, 0 = quiet compare |
| opa_i | input | 64 | Operand a |
| opb_i | input | 64 | Operand b |
| vld_o | output | 1 | Result produced in the previous cycle |
| flags_o | output | 4 | Condition flags: N, Z, C, V from bit 3 down to bit 0 |
| inv_o | output | 1 | Invalid-operation exception |

## Verification
The assertions check several things on every cycle. Any result that is flagged valid must be one of the four legal flag codes. The exception bit may only be set together with the unordered code. A signalling-mode request must raise the exception exactly when the result is unordered. Identical double-precision operands must give either equal or unordered. The valid timing and the holding of the flags between requests are also checked on every cycle. Only the bench's scenarios can show that specific orderings come out right: signed zeros, infinities, adjacent subnormals, the choice between quiet and signalling NaNs in quiet mode, and the fact that the upper operand half is ignored in single format. These need known operand values with known expected results.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int SP_EXP_W = 8;
    localparam int SP_FRC_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_FRC_W = 52;
    localparam int OPND_W   = 1 + DP_EXP_W + DP_FRC_W;
    localparam int MAG_W    = DP_EXP_W + DP_FRC_W;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    typedef struct packed {
        logic             is_nan;
        logic             is_snan;
        logic             is_zero;
        logic             sign;
        logic [MAG_W-1:0] mag;
    } opnd_info_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int FRC_W = 23
) (
    input  logic [EXP_W+FRC_W:0] raw_i,
    output opnd_info_t           info_o
);
    localparam int LOC_MAG_W = EXP_W + FRC_W;

    logic [EXP_W-1:0] exp_f;
    logic [FRC_W-1:0] frc_f;
    logic             exp_ones;
    logic             frc_nz;

    assign exp_f    = raw_i[LOC_MAG_W-1:FRC_W];
    assign frc_f    = raw_i[FRC_W-1:0];
    assign exp_ones = &exp_f;
    assign frc_nz   = |frc_f;

    always_comb begin
        info_o.sign    = raw_i[LOC_MAG_W];
        info_o.is_nan  = exp_ones && frc_nz;
        info_o.is_snan = exp_ones && frc_nz && !frc_f[FRC_W-1];
        info_o.is_zero = (exp_f == '0) && !frc_nz;
    end

    generate
        if (LOC_MAG_W < MAG_W) begin : g_pad
            assign info_o.mag = {{(MAG_W-LOC_MAG_W){1'b0}}, raw_i[LOC_MAG_W-1:0]};
        end else begin : g_full
            assign info_o.mag = raw_i[LOC_MAG_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  opnd_info_t x_i,
    input  opnd_info_t y_i,
    output rel_e       rel_o
);
    logic mag_gt;
    logic mag_eq;

    assign mag_gt = x_i.mag > y_i.mag;
    assign mag_eq = x_i.mag == y_i.mag;

    always_comb begin
        if (x_i.is_nan || y_i.is_nan) begin
            rel_o = REL_UN;
        end else if (x_i.is_zero && y_i.is_zero) begin
            rel_o = REL_EQ;
        end else if (x_i.sign != y_i.sign) begin
            rel_o = x_i.sign ? REL_LT : REL_GT;
        end else if (mag_eq) begin
            rel_o = REL_EQ;
        end else if (x_i.sign) begin
            rel_o = mag_gt ? REL_LT : REL_GT;
        end else begin
            rel_o = mag_gt ? REL_GT : REL_LT;
        end
    end

endmodule

// File: rtl/fcmp_encode.sv
module fcmp_encode
    import fcmp_pkg::*;
(
    input  rel_e  rel_i,
    input  logic  snan_any_i,
    input  logic  sig_mode_i,
    output nzcv_t flags_o,
    output logic  inv_o
);
    always_comb begin
        flags_o = '0;
        inv_o   = 1'b0;
        unique case (rel_i)
            REL_EQ: begin
                flags_o.z = 1'b1;
                flags_o.c = 1'b1;
            end
            REL_LT: flags_o.n = 1'b1;
            REL_GT: flags_o.c = 1'b1;
            REL_UN: begin
                flags_o.c = 1'b1;
                flags_o.v = 1'b1;
                inv_o     = sig_mode_i || snan_any_i;
            end
            default: flags_o = '0;
        endcase
    end

endmodule

// File: rtl/fcmp_nzcv_top.sv
module fcmp_nzcv_top
    import fcmp_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        req_i,
    input  logic        fmt_dbl_i,
    input  logic        sig_mode_i,
    input  logic [63:0] opa_i,
    input  logic [63:0] opb_i,
    output logic        vld_o,
    output logic [3:0]  flags_o,
    output logic        inv_o
);
    localparam int SP_W = 1 + SP_EXP_W + SP_FRC_W;
    localparam int N_OP = 2;

    logic [OPND_W-1:0] raw [N_OP];
    opnd_info_t        sp_info [N_OP];
    opnd_info_t        dp_info [N_OP];
    opnd_info_t        sel_info [N_OP];

    assign raw[0] = opa_i;
    assign raw[1] = opb_i;

    generate
        for (genvar k = 0; k < N_OP; k++) begin : g_op
            fcmp_classify #(.EXP_W(SP_EXP_W), .FRC_W(SP_FRC_W)) u_sp (
                .raw_i  (raw[k][SP_W-1:0]),
                .info_o (sp_info[k])
            );
            fcmp_classify #(.EXP_W(DP_EXP_W), .FRC_W(DP_FRC_W)) u_dp (
                .raw_i  (raw[k]),
                .info_o (dp_info[k])
            );
            assign sel_info[k] = fmt_dbl_i ? dp_info[k] : sp_info[k];
        end
    endgenerate

    rel_e  rel;
    nzcv_t flags_d;
    logic  inv_d;

    fcmp_order u_order (
        .x_i   (sel_info[0]),
        .y_i   (sel_info[1]),
        .rel_o (rel)
    );

    fcmp_encode u_enc (
        .rel_i      (rel),
        .snan_any_i (sel_info[0].is_snan || sel_info[1].is_snan),
        .sig_mode_i (sig_mode_i),
        .flags_o    (flags_d),
        .inv_o      (inv_d)
    );

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = req_i ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    nzcv_t flags_q;
    logic  inv_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flags_q <= '0;
            inv_q   <= 1'b0;
        end else if (req_i) begin
            flags_q <= flags_d;
            inv_q   <= inv_d;
        end
    end

    assign vld_o   = (state_q == ST_DONE);
    assign flags_o = flags_q;
    assign inv_o   = inv_q;

endmodule

// File: rtl/fcmp_nzcv_chk.sv
module fcmp_nzcv_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_i,
    input logic        fmt_dbl_i,
    input logic        sig_mode_i,
    input logic [63:0] opa_i,
    input logic [63:0] opb_i,
    input logic        vld_o,
    input logic [3:0]  flags_o,
    input logic        inv_o
);
    AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_o |-> (flags_o == 4'b0110 || flags_o == 4'b1000 || flags_o == 4'b0010 || flags_o == 4'b0011)); // R1
    AST_INV_ONLY_UNORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_o && inv_o) |-> (flags_o == 4'b0011)); // R5
    AST_SIG_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && sig_mode_i) |=> (inv_o == (flags_o == 4'b0011))); // R6
    AST_SELF_EQUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && fmt_dbl_i && (opa_i == opb_i)) |=> (flags_o == 4'b0110 || flags_o == 4'b0011)); // R1
    AST_VLD_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> vld_o); // R11
    AST_VLD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !vld_o); // R11
    AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> ($stable(flags_o) && $stable(inv_o))); // R11
endmodule

bind fcmp_nzcv_top fcmp_nzcv_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .fmt_dbl_i  (fmt_dbl_i),
    .sig_mode_i (sig_mode_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .vld_o      (vld_o),
    .flags_o    (flags_o),
    .inv_o      (inv_o)
);

// File: tb/fcmp_nzcv_top_tb_top.sv
module fcmp_nzcv_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        sig_mode = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        vld;
    logic [3:0]  flags;
    logic        inv;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    localparam logic [3:0] F_EQ = 4'b0110;
    localparam logic [3:0] F_LT = 4'b1000;
    localparam logic [3:0] F_GT = 4'b0010;
    localparam logic [3:0] F_UN = 4'b0011;

    always #5 clk = ~clk;

    fcmp_nzcv_top dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .fmt_dbl_i  (fmt_dbl),
        .sig_mode_i (sig_mode),
        .opa_i      (opa),
        .opb_i      (opb),
        .vld_o      (vld),
        .flags_o    (flags),
        .inv_o      (inv)
    );

    task automatic check(input string req_tag, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual vld/flags/inv=%b expected=%b", req_tag, act, exp);
        end
    endtask

    task automatic run_cmp(input logic [63:0] a, input logic [63:0] b, input logic dbl,
                           input logic sg, input logic [3:0] ef, input logic ei, input string tag);
        @(negedge clk);
        opa = a; opb = b; fmt_dbl = dbl; sig_mode = sg; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(tag, {vld, flags, inv}, {1'b1, ef, ei});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R12 in reset", {vld, flags, inv}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", {vld, flags, inv}, 6'b0);
    endtask

    task automatic t_equal();
        run_cmp(64'h3f800000, 64'h3f800000, 1'b0, 1'b0, F_EQ, 1'b0, "R1 sp equal");
        run_cmp(64'h3ff0000000000000, 64'h3ff0000000000000, 1'b1, 1'b1, F_EQ, 1'b0, "R1 dp equal");
    endtask

    task automatic t_less();
        run_cmp(64'h3f800000, 64'h40000000, 1'b0, 1'b0, F_LT, 1'b0, "R2 sp 1<2");
        run_cmp(64'hbff0000000000000, 64'hc000000000000000, 1'b1, 1'b0, F_GT, 1'b0, "R2 dp -1>-2");
        run_cmp(64'hc000000000000000, 64'h3ff0000000000000, 1'b1, 1'b0, F_LT, 1'b0, "R2 dp -2<1");
    endtask

    task automatic t_greater();
        run_cmp(64'h40000000, 64'hbf800000, 1'b0, 1'b0, F_GT, 1'b0, "R3 sp 2>-1");
        run_cmp(64'h4000000000000000, 64'h3ff0000000000000, 1'b1, 1'b0, F_GT, 1'b0, "R3 dp 2>1");
    endtask

    task automatic t_unordered();
        run_cmp(64'h7fc00000, 64'h3f800000, 1'b0, 1'b0, F_UN, 1'b0, "R4 sp qnan a");
        run_cmp(64'h3ff0000000000000, 64'h7ff8000000000000, 1'b1, 1'b0, F_UN, 1'b0, "R4 dp qnan b");
    endtask

    task automatic t_quiet_inv();
        run_cmp(64'h7f800001, 64'h3f800000, 1'b0, 1'b0, F_UN, 1'b1, "R5 sp snan quiet");
        run_cmp(64'h0, 64'h7ff0000000000001, 1'b1, 1'b0, F_UN, 1'b1, "R5 dp snan quiet");
        run_cmp(64'hffc00000, 64'h7fc00000, 1'b0, 1'b0, F_UN, 1'b0, "R5 two qnan quiet");
    endtask

    task automatic t_sig_inv();
        run_cmp(64'h7fc00000, 64'h3f800000, 1'b0, 1'b1, F_UN, 1'b1, "R6 sp qnan sig");
        run_cmp(64'h7ff8000000000000, 64'h0, 1'b1, 1'b1, F_UN, 1'b1, "R6 dp qnan sig");
        run_cmp(64'h3f800000, 64'h40000000, 1'b0, 1'b1, F_LT, 1'b0, "R6 ordered sig");
    endtask

    task automatic t_format();
        run_cmp(64'hffffffff_3f800000, 64'h00000000_40000000, 1'b0, 1'b0, F_LT, 1'b0, "R7 sp upper ignored");
        run_cmp(64'hffffffff_3f800000, 64'h00000000_40000000, 1'b1, 1'b0, F_UN, 1'b0, "R7 dp full width");
    endtask

    task automatic t_zero();
        run_cmp(64'h80000000, 64'h00000000, 1'b0, 1'b0, F_EQ, 1'b0, "R8 sp -0==+0");
        run_cmp(64'h0, 64'h8000000000000000, 1'b1, 1'b0, F_EQ, 1'b0, "R8 dp +0==-0");
    endtask

    task automatic t_inf();
        run_cmp(64'hff800000, 64'hff7fffff, 1'b0, 1'b0, F_LT, 1'b0, "R9 -inf<-max");
        run_cmp(64'h7ff0000000000000, 64'h7fefffffffffffff, 1'b1, 1'b0, F_GT, 1'b0, "R9 +inf>max");
        run_cmp(64'h7f800000, 64'h7f800000, 1'b0, 1'b1, F_EQ, 1'b0, "R9 +inf==+inf");
        run_cmp(64'hfff0000000000000, 64'hfff0000000000000, 1'b1, 1'b0, F_EQ, 1'b0, "R9 -inf==-inf");
    endtask

    task automatic t_denorm();
        run_cmp(64'h00000001, 64'h00000002, 1'b0, 1'b0, F_LT, 1'b0, "R10 sp denorm");
        run_cmp(64'h8000000000000001, 64'h0, 1'b1, 1'b0, F_LT, 1'b0, "R10 dp -denorm<0");
        run_cmp(64'h0000000000000001, 64'h0, 1'b1, 1'b0, F_GT, 1'b0, "R10 dp denorm>0");
    endtask

    task automatic t_timing();
        run_cmp(64'h40000000, 64'h3f800000, 1'b0, 1'b0, F_GT, 1'b0, "R11 setup");
        opa = 64'h0; opb = 64'h3f800000;
        @(negedge clk);
        check("R11 idle holds", {vld, flags, inv}, {1'b0, F_GT, 1'b0});
        req = 1'b1; opa = 64'h3f800000; opb = 64'h40000000; fmt_dbl = 1'b0;
        @(negedge clk);
        check("R11 first of pair", {vld, flags, inv}, {1'b1, F_LT, 1'b0});
        opa = 64'h7f800001; opb = 64'h0;
        @(negedge clk);
        req = 1'b0;
        check("R11 back to back", {vld, flags, inv}, {1'b1, F_UN, 1'b1});
        @(negedge clk);
        check("R11 retire", {vld, flags, inv}, {1'b0, F_UN, 1'b1});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_equal();
        t_less();
        t_greater();
        t_unordered();
        t_quiet_inv();
        t_sig_inv();
        t_format();
        t_zero();
        t_inf();
        t_denorm();
        t_timing();
        finish_run();
    end

endmodule